// File: doc/BRIEF.md
# Low-Power Mode Sequencer

This block decides when a small processor core may stop its clocks and when it must start them again. It has three resting states, Run, Idle and Sleep, plus an internal warm-up phase that follows Sleep. The core asks for a low-power state with a single-cycle request that carries a mode select. The block then drives three enables: one for the CPU clock, one for the peripheral clocks and one for the oscillator. In Idle only the CPU clock stops. In Sleep the oscillator stops as well, so leaving Sleep takes a counted start-up delay and a clock-stable indication.

Three events end a low-power state. The first is an interrupt that the interrupt controller has already found to be both enabled and of sufficient priority. The second is a warm (non power-on) reset pulse. The third is a watchdog time-out pulse. The event that caused the wake-up is reported as a code for one cycle when Run is re-entered. Three sticky flags record why the core woke: a Sleep flag, an Idle flag and a watchdog flag. Software clears them with a write-one-to-clear strobe, and power-on reset clears them. Every pin is a plain level or strobe, and none carries data, so there is no handshake at the edge of the block.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: After power-on reset the block is in Run. `cpu_clk_en`, `per_clk_en` and `osc_en` are 1, all three flags are 0 and `wake_valid` is 0.
- R2: In Run with no wake condition present, an `enter_req` with `enter_mode`=0 enters Idle one cycle later. In Idle, `cpu_clk_en`=0, `per_clk_en`=1 and `osc_en`=1.
- R3: The same request with `enter_mode`=1 enters Sleep. In Sleep, `cpu_clk_en`, `per_clk_en` and `osc_en` are all 0.
- R4: Any one of `irq_wake`, `wdt_timeout` or `warm_rst` ends Idle or Sleep.
- R5: A wake condition in Idle puts the block back in Run at the next clock edge, with `cpu_clk_en`=1 in that first cycle.
- R6: A wake condition in Sleep starts a warm-up in which `osc_en`=1 and `cpu_clk_en`=0. Run resumes only at the edge that follows the cycle in which two things are true: DELAY_TICKS `ref_tick` strobes have been counted, and `osc_stable` is 1. The strobes are counted from the edge after the wake.
- R7: Waking from Sleep sets `flag_sleep` and waking from Idle sets `flag_idle`. In both cases the flag is set at the edge that takes the wake condition.
- R8: A wake caused by `wdt_timeout` also sets `flag_wdto`. A watchdog pulse seen outside Idle or Sleep sets no flag.
- R9: Power-on reset clears all flags asynchronously and forces Run. `warm_rst` seen while in Run changes no flag and no enable.
- R10: `clr_flags` is a write-one-to-clear strobe. Bit 0 clears the Sleep flag, bit 1 the Idle flag and bit 2 the watchdog flag. If a set and a clear reach the same flag in the same cycle, the set wins.
- R11: An `enter_req` that arrives while any wake condition is present is ignored, and the block stays in Run.
- R12: `wake_cause` is valid for exactly one cycle, the first cycle back in Run, with `wake_valid`=1. The codes are 2'b01 interrupt, 2'b10 watchdog and 2'b11 reset. When several causes are present together, reset ranks above watchdog and watchdog above interrupt. When `wake_valid` is 0, the code is 2'b00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| enter_req | input | 1 | One-cycle request to leave Run |
| enter_mode | input | 1 | 0 selects Idle, 1 selects Sleep |
| irq_wake | input | 1 | Enabled, priority-qualified interrupt pending |
| wdt_timeout | input | 1 | Watchdog time-out strobe |
| warm_rst | input | 1 | Non power-on reset strobe |
| ref_tick | input | 1 | Strobe from the low-speed reference clock |
| osc_stable | input | 1 | Oscillator is running and stable |
| clr_flags | input | 3 | Write-one-to-clear strobes {wdto, idle, sleep} |
| cpu_clk_en | output | 1 | CPU clock enable |
| per_clk_en | output | 1 | Peripheral clock enable |
| osc_en | output | 1 | Oscillator enable |
| flag_sleep | output | 1 | Sticky: woke from Sleep |
| flag_idle | output | 1 | Sticky: woke from Idle |
| flag_wdto | output | 1 | Sticky: woke by watchdog |
| wake_valid | output | 1 | One-cycle strobe on return to Run |
| wake_cause | output | 2 | Wake cause code, meaningful while wake_valid is 1 |

## Verification
A wrong state register shows up in the three enables during the cycle that follows the bad transition. For example, Idle entered in place of Sleep leaves `osc_en` high at once. A warm-up counter that is off by one moves the rise of `cpu_clk_en` by one cycle, so the bench counts the edges from the wake to the return to Run exactly. A flag that is set in the wrong place, or a cause that is latched wrongly, appears in the flags or in `wake_cause` in the first Run cycle. The checks are placed in that cycle and in the cycle that follows it.

// File: rtl/pwr_mode_pkg.sv
package pwr_mode_pkg;

  typedef enum logic [1:0] {
    PM_RUN    = 2'd0,
    PM_IDLE   = 2'd1,
    PM_SLEEP  = 2'd2,
    PM_WARMUP = 2'd3
  } pm_state_e;

  typedef enum logic [1:0] {
    WC_NONE = 2'b00,
    WC_IRQ  = 2'b01,
    WC_WDT  = 2'b10,
    WC_RST  = 2'b11
  } wake_cause_e;

  // Flag bit order; clr_flags follows it.
  localparam int unsigned FLG_SLEEP = 0;
  localparam int unsigned FLG_IDLE  = 1;
  localparam int unsigned FLG_WDTO  = 2;
  localparam int unsigned NUM_FLAGS = 3;

  typedef struct packed {
    logic cpu;
    logic per;
    logic osc;
  } clk_en_t;

  function automatic clk_en_t decode_enables(pm_state_e st);
    clk_en_t e;
    unique case (st)
      PM_RUN:    e = '{cpu: 1'b1, per: 1'b1, osc: 1'b1};
      PM_IDLE:   e = '{cpu: 1'b0, per: 1'b1, osc: 1'b1};
      PM_SLEEP:  e = '{cpu: 1'b0, per: 1'b0, osc: 1'b0};
      default:   e = '{cpu: 1'b0, per: 1'b0, osc: 1'b1};
    endcase
    return e;
  endfunction

endpackage

// File: rtl/pwr_wake_detect.sv
module pwr_wake_detect
  import pwr_mode_pkg::*;
(
  input  logic        irq_wake,
  input  logic        wdt_timeout,
  input  logic        warm_rst,
  output logic        wake_any,
  output wake_cause_e cause
);

  always_comb begin
    wake_any = irq_wake | wdt_timeout | warm_rst;
    if (warm_rst)         cause = WC_RST;
    else if (wdt_timeout) cause = WC_WDT;
    else if (irq_wake)    cause = WC_IRQ;
    else                  cause = WC_NONE;
  end

endmodule

// File: rtl/pwr_startup_timer.sv
module pwr_startup_timer #(
  parameter int unsigned DELAY_TICKS = 1024
) (
  input  logic clk,
  input  logic por_n,
  input  logic run_en,
  input  logic tick,
  output logic done
);

  localparam int unsigned CNT_W = $clog2(DELAY_TICKS + 1);
  localparam logic [CNT_W-1:0] LIMIT = CNT_W'(DELAY_TICKS);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)               cnt_q <= '0;
    else if (!run_en)         cnt_q <= '0;
    else if (tick && !done)   cnt_q <= cnt_q + 1'b1;
  end

  assign done = (cnt_q == LIMIT);

  assert_count_bounded_R6: assert property (@(posedge clk) disable iff (!por_n)
    cnt_q <= LIMIT);

  assert_idle_counter_clear_R6: assert property (@(posedge clk) disable iff (!por_n)
    !run_en |=> (cnt_q == '0));

endmodule

// File: rtl/pwr_status_flags.sv
module pwr_status_flags
  import pwr_mode_pkg::*;
(
  input  logic                 clk,
  input  logic                 por_n,
  input  logic [NUM_FLAGS-1:0] set_vec,
  input  logic [NUM_FLAGS-1:0] clr_vec,
  output logic [NUM_FLAGS-1:0] flags
);

  logic [NUM_FLAGS-1:0] flag_q;

  for (genvar i = 0; i < NUM_FLAGS; i++) begin : g_flag
    always_ff @(posedge clk or negedge por_n) begin
      if (!por_n)          flag_q[i] <= 1'b0;
      else if (set_vec[i]) flag_q[i] <= 1'b1;
      else if (clr_vec[i]) flag_q[i] <= 1'b0;
    end

    assert_set_sticks_R7: assert property (@(posedge clk) disable iff (!por_n)
      set_vec[i] |=> flag_q[i]);

    assert_w1c_clears_R10: assert property (@(posedge clk) disable iff (!por_n)
      (clr_vec[i] && !set_vec[i]) |=> !flag_q[i]);

    assert_hold_R10: assert property (@(posedge clk) disable iff (!por_n)
      (!clr_vec[i] && !set_vec[i]) |=> $stable(flag_q[i]));
  end

  assign flags = flag_q;

endmodule

// File: rtl/pwr_mode_ctrl.sv
module pwr_mode_ctrl
  import pwr_mode_pkg::*;
#(
  parameter int unsigned DELAY_TICKS = 1024
) (
  input  logic       clk,
  input  logic       por_n,
  input  logic       enter_req,
  input  logic       enter_mode,
  input  logic       irq_wake,
  input  logic       wdt_timeout,
  input  logic       warm_rst,
  input  logic       ref_tick,
  input  logic       osc_stable,
  input  logic [2:0] clr_flags,
  output logic       cpu_clk_en,
  output logic       per_clk_en,
  output logic       osc_en,
  output logic       flag_sleep,
  output logic       flag_idle,
  output logic       flag_wdto,
  output logic       wake_valid,
  output logic [1:0] wake_cause
);

  pm_state_e   state_q, state_d;
  wake_cause_e evt_cause;
  wake_cause_e held_cause_q;
  wake_cause_e cause_q;
  logic        wake_any;
  logic        warm_done;
  logic        valid_q;
  logic        idle_wake, sleep_wake, warm_exit;
  logic [NUM_FLAGS-1:0] flag_set, flag_vec;
  clk_en_t     en;

  pwr_wake_detect u_detect (
    .irq_wake    (irq_wake),
    .wdt_timeout (wdt_timeout),
    .warm_rst    (warm_rst),
    .wake_any    (wake_any),
    .cause       (evt_cause)
  );

  pwr_startup_timer #(.DELAY_TICKS(DELAY_TICKS)) u_timer (
    .clk    (clk),
    .por_n  (por_n),
    .run_en (state_q == PM_WARMUP),
    .tick   (ref_tick),
    .done   (warm_done)
  );

  assign idle_wake  = (state_q == PM_IDLE)   && wake_any;
  assign sleep_wake = (state_q == PM_SLEEP)  && wake_any;
  assign warm_exit  = (state_q == PM_WARMUP) && warm_done && osc_stable;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      PM_RUN:    if (enter_req && !wake_any) state_d = enter_mode ? PM_SLEEP : PM_IDLE;
      PM_IDLE:   if (wake_any)               state_d = PM_RUN;
      PM_SLEEP:  if (wake_any)               state_d = PM_WARMUP;
      default:   if (warm_done && osc_stable) state_d = PM_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      state_q      <= PM_RUN;
      held_cause_q <= WC_NONE;
      cause_q      <= WC_NONE;
      valid_q      <= 1'b0;
    end else begin
      state_q <= state_d;
      if (sleep_wake) held_cause_q <= evt_cause;
      valid_q <= idle_wake || warm_exit;
      if (idle_wake)      cause_q <= evt_cause;
      else if (warm_exit) cause_q <= held_cause_q;
      else                cause_q <= WC_NONE;
    end
  end

  always_comb begin
    flag_set            = '0;
    flag_set[FLG_SLEEP] = sleep_wake;
    flag_set[FLG_IDLE]  = idle_wake;
    flag_set[FLG_WDTO]  = (idle_wake || sleep_wake) && wdt_timeout;
  end

  pwr_status_flags u_flags (
    .clk     (clk),
    .por_n   (por_n),
    .set_vec (flag_set),
    .clr_vec (clr_flags),
    .flags   (flag_vec)
  );

  assign en         = decode_enables(state_q);
  assign cpu_clk_en = en.cpu;
  assign per_clk_en = en.per;
  assign osc_en     = en.osc;
  assign flag_sleep = flag_vec[FLG_SLEEP];
  assign flag_idle  = flag_vec[FLG_IDLE];
  assign flag_wdto  = flag_vec[FLG_WDTO];
  assign wake_valid = valid_q;
  assign wake_cause = cause_q;

  assert_idle_zero_delay_R5: assert property (@(posedge clk) disable iff (!por_n)
    idle_wake |=> (cpu_clk_en && wake_valid));

  assert_enter_blocked_R11: assert property (@(posedge clk) disable iff (!por_n)
    (state_q == PM_RUN && enter_req && wake_any) |=> cpu_clk_en);

  assert_warmup_waits_osc_R6: assert property (@(posedge clk) disable iff (!por_n)
    (state_q == PM_WARMUP && !osc_stable) |=> !cpu_clk_en);

  assert_valid_one_cycle_R12: assert property (@(posedge clk) disable iff (!por_n)
    wake_valid |=> !wake_valid);

  assert_valid_has_cause_R12: assert property (@(posedge clk) disable iff (!por_n)
    wake_valid |-> (wake_cause != WC_NONE) && cpu_clk_en);

  assert_wdto_on_wake_R8: assert property (@(posedge clk) disable iff (!por_n)
    $rose(flag_wdto) |-> (wake_valid || state_q == PM_WARMUP));

  assert_sleep_wake_warms_R6: assert property (@(posedge clk) disable iff (!por_n)
    sleep_wake |=> (osc_en && !cpu_clk_en));

endmodule

// File: tb/pwr_mode_ctrl_tb.sv
module pwr_mode_ctrl_tb;

  localparam int unsigned DLY = 16;

  logic       clk = 1'b0;
  logic       por_n = 1'b0;
  logic       enter_req = 1'b0, enter_mode = 1'b0;
  logic       irq_wake = 1'b0, wdt_timeout = 1'b0, warm_rst = 1'b0;
  logic       ref_tick = 1'b1, osc_stable = 1'b1;
  logic [2:0] clr_flags = 3'b000;
  logic       cpu_clk_en, per_clk_en, osc_en;
  logic       flag_sleep, flag_idle, flag_wdto;
  logic       wake_valid;
  logic [1:0] wake_cause;

  int n_cmp = 0;
  int n_err = 0;

  always #4 clk = ~clk;

  pwr_mode_ctrl #(.DELAY_TICKS(DLY)) u_dut (
    .clk(clk), .por_n(por_n), .enter_req(enter_req), .enter_mode(enter_mode),
    .irq_wake(irq_wake), .wdt_timeout(wdt_timeout), .warm_rst(warm_rst),
    .ref_tick(ref_tick), .osc_stable(osc_stable), .clr_flags(clr_flags),
    .cpu_clk_en(cpu_clk_en), .per_clk_en(per_clk_en), .osc_en(osc_en),
    .flag_sleep(flag_sleep), .flag_idle(flag_idle), .flag_wdto(flag_wdto),
    .wake_valid(wake_valid), .wake_cause(wake_cause)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic enter(input logic mode);
    @(negedge clk); enter_req = 1'b1; enter_mode = mode;
    @(negedge clk); enter_req = 1'b0;
  endtask

  task automatic clear_all;
    @(negedge clk); clr_flags = 3'b111;
    @(negedge clk); clr_flags = 3'b000;
    chk("R10", "flags after clear", {flag_wdto, flag_idle, flag_sleep}, 0);
  endtask

  task automatic t_reset_state;
    chk("R1", "enables", {cpu_clk_en, per_clk_en, osc_en}, 3'b111);
    chk("R1", "flags", {flag_wdto, flag_idle, flag_sleep}, 0);
    chk("R1", "wake_valid", wake_valid, 0);
  endtask

  task automatic t_idle_irq;
    clear_all();
    enter(1'b0);
    chk("R2", "idle enables", {cpu_clk_en, per_clk_en, osc_en}, 3'b011);
    irq_wake = 1'b1;
    @(negedge clk); irq_wake = 1'b0;
    chk("R5", "cpu after idle wake", cpu_clk_en, 1);
    chk("R12", "valid", wake_valid, 1);
    chk("R12", "cause irq", wake_cause, 1);
    chk("R7", "flag_idle", flag_idle, 1);
    chk("R7", "flag_sleep", flag_sleep, 0);
    @(negedge clk);
    chk("R12", "valid drops", wake_valid, 0);
    chk("R12", "cause none", wake_cause, 0);
  endtask

  task automatic t_idle_wdt_priority;
    clear_all();
    enter(1'b0);
    wdt_timeout = 1'b1; irq_wake = 1'b1;
    @(negedge clk); wdt_timeout = 1'b0; irq_wake = 1'b0;
    chk("R12", "wdt over irq", wake_cause, 2);
    chk("R8", "flag_wdto", flag_wdto, 1);
    chk("R4", "cpu back", cpu_clk_en, 1);
  endtask

  task automatic t_sleep_delay;
    bit early;
    clear_all();
    enter(1'b1);
    chk("R3", "sleep enables", {cpu_clk_en, per_clk_en, osc_en}, 3'b000);
    irq_wake = 1'b1;
    @(negedge clk); irq_wake = 1'b0;
    chk("R6", "warmup osc/cpu", {osc_en, cpu_clk_en}, 2'b10);
    chk("R7", "flag_sleep", flag_sleep, 1);
    early = 1'b0;
    for (int k = 1; k <= int'(DLY); k++) begin
      @(negedge clk);
      if (cpu_clk_en) early = 1'b1;
    end
    chk("R6", "cpu held during delay", early, 0);
    @(negedge clk);
    chk("R6", "cpu on after delay", cpu_clk_en, 1);
    chk("R12", "cause irq", wake_cause, 1);
    chk("R12", "valid", wake_valid, 1);
  endtask

  task automatic t_sleep_osc_wait;
    bit early;
    clear_all();
    osc_stable = 1'b0;
    enter(1'b1);
    wdt_timeout = 1'b1;
    @(negedge clk); wdt_timeout = 1'b0;
    chk("R8", "wdto and sleep flags", {flag_wdto, flag_sleep}, 2'b11);
    early = 1'b0;
    for (int k = 0; k < int'(DLY) + 10; k++) begin
      @(negedge clk);
      if (cpu_clk_en) early = 1'b1;
    end
    chk("R6", "cpu held until osc stable", early, 0);
    osc_stable = 1'b1;
    @(negedge clk);
    chk("R6", "cpu on after stable", cpu_clk_en, 1);
    chk("R12", "cause wdt", wake_cause, 2);
  endtask

  task automatic t_sleep_warm_rst;
    clear_all();
    enter(1'b1);
    warm_rst = 1'b1; irq_wake = 1'b1; wdt_timeout = 1'b1;
    @(negedge clk); warm_rst = 1'b0; irq_wake = 1'b0; wdt_timeout = 1'b0;
    repeat (DLY + 1) @(negedge clk);
    chk("R12", "reset ranks first", wake_cause, 3);
    chk("R9", "warm reset sets sleep flag", flag_sleep, 1);
    chk("R4", "cpu back", cpu_clk_en, 1);
  endtask

  task automatic t_run_ignores;
    clear_all();
    warm_rst = 1'b1; wdt_timeout = 1'b1;
    @(negedge clk); warm_rst = 1'b0; wdt_timeout = 1'b0;
    chk("R9", "warm reset in run: flags", {flag_wdto, flag_idle, flag_sleep}, 0);
    chk("R8", "wdt in run: enables", {cpu_clk_en, per_clk_en, osc_en}, 3'b111);
    irq_wake = 1'b1; enter_req = 1'b1; enter_mode = 1'b1;
    @(negedge clk); enter_req = 1'b0; irq_wake = 1'b0;
    chk("R11", "blocked enter", {cpu_clk_en, per_clk_en, osc_en}, 3'b111);
    chk("R11", "no wake strobe", wake_valid, 0);
    @(negedge clk);
    chk("R11", "still run", cpu_clk_en, 1);
  endtask

  task automatic t_set_beats_clear;
    clear_all();
    enter(1'b0);
    irq_wake = 1'b1; clr_flags = 3'b010;
    @(negedge clk); irq_wake = 1'b0; clr_flags = 3'b000;
    chk("R10", "set wins", flag_idle, 1);
    @(negedge clk); clr_flags = 3'b001;
    @(negedge clk); clr_flags = 3'b000;
    chk("R10", "other bit leaves idle", flag_idle, 1);
  endtask

  task automatic t_por;
    enter(1'b1);
    #1 por_n = 1'b0;
    #1;
    chk("R9", "por forces run", cpu_clk_en, 1);
    chk("R9", "por clears flags", {flag_wdto, flag_idle, flag_sleep}, 0);
    @(negedge clk); por_n = 1'b1;
    @(negedge clk);
    chk("R1", "run after por", {cpu_clk_en, per_clk_en, osc_en}, 3'b111);
  endtask

  initial begin
    #(8 * 100000);
    n_err++;
    $display("FAIL watchdog: actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_err);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    por_n = 1'b1;
    @(negedge clk);
    t_reset_state();
    t_idle_irq();
    t_idle_wdt_priority();
    t_sleep_delay();
    t_sleep_osc_wait();
    t_sleep_warm_rst();
    t_run_ignores();
    t_set_beats_clear();
    t_por();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_err);
    $finish;
  end

endmodule